// File: doc/BRIEF.md
# Programmable TFT Panel Timing Generator

This block produces the raster timing for a parallel TFT panel. A divider turns the system clock into a pixel strobe and a matching pixel clock output. Two segment counters walk each line and each frame through four phases in turn: sync, back porch, active region and front porch. From these counts the block drives horizontal sync, vertical sync, data enable, the coordinates of the current active pixel, and one-cycle pulses that mark the start of each line and of each frame.

Every timing value arrives on plain configuration inputs. Each length field holds its count minus one. A control word carries the run enable, three polarity inversions and the pixel clock edge select. The whole set is copied into shadow registers at the start of each frame, and continuously while the block is stopped. A frame therefore never mixes two timing sets. Clearing the run bit stops everything at once, and setting it again starts a fresh frame at pixel 0 of line 0.

Top module: `tft_timing_gen`

## Requirements
- R1: `pix_stb_o` is high for exactly one system clock in every pixel period of 2*(D+1) system clocks, where D is the latched `clk_div_i`.
- R2: Within each pixel period, `pix_clk_o` is high for the first D+1 cycles and low for the last D+1 cycles when `ctrl_i[4]`=0 (panel captures on the falling edge). The phases are swapped when `ctrl_i[4]`=1 (panel captures on the rising edge). `pix_clk_o` is low while stopped.
- R3: A line lasts (HS+1)+(HB+1)+(HA+1)+(HF+1) pixel periods, in the order sync, back porch, active, front porch. Horizontal sync is active during the first HS+1 pixels, so the back porch spans HB+1 pixels from sync release to the first active pixel.
- R4: A frame lasts (VS+1)+(VB+1)+(VA+1)+(VF+1) lines in the same order. Vertical sync is active for the first VS+1 whole lines.
- R5: Data enable is active exactly when both the horizontal and the vertical position are in their active regions. During that time `x_o` and `y_o` give the pixel and line offsets from the first active pixel and line. Both are 0 while data enable is inactive.
- R6: `ctrl_i[1]`, `ctrl_i[2]` and `ctrl_i[3]` invert `hsync_o`, `vsync_o` and `den_o` respectively. With a bit clear, its signal is active high.
- R7: While `ctrl_i[0]` (run) is 0 from the previous clock, or while reset is active, all counters are held at 0. Sync and enable outputs sit at their inactive level, and strobe, pulses and coordinates are 0. After reset all outputs are 0.
- R8: Configuration inputs are latched only at the clock edge that wraps the frame, and at every edge while stopped. A change made mid-frame takes effect with the next frame.
- R9: `line_start_o` is high for the first system clock of every line. `frame_start_o` is high for the first system clock of every frame, including the first frame after run is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 5 | bit0 run, bit1 hsync invert, bit2 vsync invert, bit3 den invert, bit4 rising-edge capture |
| clk_div_i | input | DIV_W | Divider value D |
| h_sync_i | input | H_W | Horizontal sync width minus one |
| h_back_i | input | H_W | Horizontal back porch minus one |
| h_act_i | input | H_W | Active width minus one |
| h_front_i | input | H_W | Horizontal front porch minus one |
| v_sync_i | input | V_W | Vertical sync lines minus one |
| v_back_i | input | V_W | Vertical back porch lines minus one |
| v_act_i | input | V_W | Active lines minus one |
| v_front_i | input | V_W | Vertical front porch lines minus one |
| pix_stb_o | output | 1 | One-cycle strobe per pixel period |
| pix_clk_o | output | 1 | Pixel clock to panel |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| den_o | output | 1 | Data enable |
| x_o | output | H_W | Active pixel offset |
| y_o | output | V_W | Active line offset |
| line_start_o | output | 1 | First cycle of each line |
| frame_start_o | output | 1 | First cycle of each frame |

## Verification
The bench targets the minimum geometry, where every field is 0 and the divider is 0. In that case each phase lasts one pixel and an off-by-one in any segment boundary shifts sync or enable by a whole pixel or line. It rewrites the configuration mid-frame: a design that applies new values at once produces a line or frame of mixed length, and the per-cycle comparison shows the sync edge out of place. It also drops run mid-frame and raises it again. A design that keeps its counters would resume mid-line instead of raising `frame_start_o` at pixel 0, and one that ignores inversion while stopped would idle the syncs at the wrong level.

// File: rtl/tft_timing_pkg.sv
package tft_timing_pkg;
  localparam int unsigned CTRL_W      = 5;
  localparam int unsigned CTRL_RUN    = 0;
  localparam int unsigned CTRL_INV_H  = 1;
  localparam int unsigned CTRL_INV_V  = 2;
  localparam int unsigned CTRL_INV_DE = 3;
  localparam int unsigned CTRL_RISE   = 4;

  typedef struct packed {
    logic rise;
    logic inv_de;
    logic inv_v;
    logic inv_h;
  } pol_t;
endpackage

// File: rtl/tft_clk_div.sv
module tft_clk_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             stb_o,
  output logic             phase_hi_o
);
  localparam int unsigned CW = DIV_W + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last       = {div_i, 1'b1};  // 2*(D+1)-1
  assign stb_o      = run_i && (cnt_q == last);
  assign phase_hi_o = cnt_q <= {1'b0, div_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (stb_o)  cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  a_r1_div_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last);
  a_r1_stb_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |=> !stb_o);
endmodule

// File: rtl/tft_axis_cnt.sv
module tft_axis_cnt #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         step_i,
  input  logic [W-1:0] sync_len_i,
  input  logic [W-1:0] back_len_i,
  input  logic [W-1:0] act_len_i,
  input  logic [W-1:0] front_len_i,
  output logic         wrap_o,
  output logic         sync_o,
  output logic         act_o,
  output logic [W-1:0] pos_o
);
  localparam int unsigned CW = W + 2;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] sync_end, act_beg, act_end, last;

  assign sync_end = CW'(sync_len_i);
  assign act_beg  = sync_end + CW'(back_len_i) + CW'(2);
  assign act_end  = act_beg + CW'(act_len_i);
  assign last     = act_end + CW'(front_len_i) + CW'(1);

  assign wrap_o = run_i && step_i && (cnt_q == last);
  assign sync_o = cnt_q <= sync_end;
  assign act_o  = (cnt_q >= act_beg) && (cnt_q <= act_end);
  assign pos_o  = W'(cnt_q - act_beg);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end

  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last);
  a_r7_cnt_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/tft_timing_gen.sv
module tft_timing_gen
  import tft_timing_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned H_W   = 10,
  parameter int unsigned V_W   = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [DIV_W-1:0]  clk_div_i,
  input  logic [H_W-1:0]    h_sync_i,
  input  logic [H_W-1:0]    h_back_i,
  input  logic [H_W-1:0]    h_act_i,
  input  logic [H_W-1:0]    h_front_i,
  input  logic [V_W-1:0]    v_sync_i,
  input  logic [V_W-1:0]    v_back_i,
  input  logic [V_W-1:0]    v_act_i,
  input  logic [V_W-1:0]    v_front_i,
  output logic              pix_stb_o,
  output logic              pix_clk_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              den_o,
  output logic [H_W-1:0]    x_o,
  output logic [V_W-1:0]    y_o,
  output logic              line_start_o,
  output logic              frame_start_o
);
  typedef struct packed {
    pol_t             pol;
    logic [DIV_W-1:0] div;
    logic [H_W-1:0]   hs, hb, ha, hf;
    logic [V_W-1:0]   vs, vb, va, vf;
  } cfg_t;

  cfg_t           cfg_q, cfg_in;
  logic           run_q, fs_q, ls_q;
  logic           stb, phase_hi;
  logic           h_wrap, h_sync, h_act;
  logic           v_wrap, v_sync, v_act;
  logic [H_W-1:0] h_pos;
  logic [V_W-1:0] v_pos;
  logic           den_act;

  assign cfg_in.pol.rise   = ctrl_i[CTRL_RISE];
  assign cfg_in.pol.inv_de = ctrl_i[CTRL_INV_DE];
  assign cfg_in.pol.inv_v  = ctrl_i[CTRL_INV_V];
  assign cfg_in.pol.inv_h  = ctrl_i[CTRL_INV_H];
  assign cfg_in.div = clk_div_i;
  assign cfg_in.hs  = h_sync_i;
  assign cfg_in.hb  = h_back_i;
  assign cfg_in.ha  = h_act_i;
  assign cfg_in.hf  = h_front_i;
  assign cfg_in.vs  = v_sync_i;
  assign cfg_in.vb  = v_back_i;
  assign cfg_in.va  = v_act_i;
  assign cfg_in.vf  = v_front_i;

  // shadow follows inputs while stopped, otherwise only at frame wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      fs_q  <= 1'b0;
      ls_q  <= 1'b0;
      cfg_q <= '0;
    end else begin
      run_q <= ctrl_i[CTRL_RUN];
      fs_q  <= ctrl_i[CTRL_RUN] & (~run_q | v_wrap);
      ls_q  <= ctrl_i[CTRL_RUN] & (~run_q | h_wrap);
      if (!run_q || v_wrap) cfg_q <= cfg_in;
    end
  end

  tft_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni,
    .run_i      (run_q),
    .div_i      (cfg_q.div),
    .stb_o      (stb),
    .phase_hi_o (phase_hi)
  );

  tft_axis_cnt #(.W(H_W)) u_h (
    .clk_i, .rst_ni,
    .run_i       (run_q),
    .step_i      (stb),
    .sync_len_i  (cfg_q.hs),
    .back_len_i  (cfg_q.hb),
    .act_len_i   (cfg_q.ha),
    .front_len_i (cfg_q.hf),
    .wrap_o      (h_wrap),
    .sync_o      (h_sync),
    .act_o       (h_act),
    .pos_o       (h_pos)
  );

  tft_axis_cnt #(.W(V_W)) u_v (
    .clk_i, .rst_ni,
    .run_i       (run_q),
    .step_i      (h_wrap),
    .sync_len_i  (cfg_q.vs),
    .back_len_i  (cfg_q.vb),
    .act_len_i   (cfg_q.va),
    .front_len_i (cfg_q.vf),
    .wrap_o      (v_wrap),
    .sync_o      (v_sync),
    .act_o       (v_act),
    .pos_o       (v_pos)
  );

  assign den_act       = run_q & h_act & v_act;
  assign pix_stb_o     = stb;
  assign pix_clk_o     = run_q & (phase_hi ^ cfg_q.pol.rise);
  assign hsync_o       = (run_q & h_sync) ^ cfg_q.pol.inv_h;
  assign vsync_o       = (run_q & v_sync) ^ cfg_q.pol.inv_v;
  assign den_o         = den_act ^ cfg_q.pol.inv_de;
  assign x_o           = den_act ? h_pos : '0;
  assign y_o           = den_act ? v_pos : '0;
  assign line_start_o  = ls_q;
  assign frame_start_o = fs_q;

  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (!pix_stb_o && !line_start_o && !frame_start_o && x_o == '0 && y_o == '0));
  a_r8_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !v_wrap) |=> $stable(cfg_q));
  a_r9_frame_is_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> line_start_o);
  a_r9_fs_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o);
  a_r5_den_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (den_act && !v_sync) |-> !h_sync);
endmodule

// File: tb/sim_tft_timing_gen.sv
`timescale 1ns/1ps
module sim_tft_timing_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [4:0] ctrl;
  logic [7:0] dv;
  logic [9:0] hs, hb, ha, hf, vs, vb, va, vf;
  logic       pix_stb_o, pix_clk_o, hsync_o, vsync_o, den_o, line_start_o, frame_start_o;
  logic [9:0] x_o, y_o;

  always #2.5 clk_i = ~clk_i;

  tft_timing_gen u0 (
    .clk_i, .rst_ni, .ctrl_i(ctrl), .clk_div_i(dv),
    .h_sync_i(hs), .h_back_i(hb), .h_act_i(ha), .h_front_i(hf),
    .v_sync_i(vs), .v_back_i(vb), .v_act_i(va), .v_front_i(vf),
    .pix_stb_o, .pix_clk_o, .hsync_o, .vsync_o, .den_o, .x_o, .y_o,
    .line_start_o, .frame_start_o
  );

  int n_chk = 0, n_fail = 0;
  int err[6];
  // bench model state
  int m_run, m_div, m_h, m_v, m_fs, m_ls;
  int k_ctrl, k_div, k_hs, k_hb, k_ha, k_hf, k_vs, k_vb, k_va, k_vf;

  task automatic check(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic latch_cfg();
    k_ctrl = ctrl; k_div = dv;
    k_hs = hs; k_hb = hb; k_ha = ha; k_hf = hf;
    k_vs = vs; k_vb = vb; k_va = va; k_vf = vf;
  endtask

  function automatic int frame_len();
    return 2 * (dv + 1) * (hs + hb + ha + hf + 4) * (vs + vb + va + vf + 4);
  endfunction

  // advance model across the next rising edge, then compare at the falling edge
  task automatic tick();
    int p, ht, vt, hb0, vb0, dena;
    bit stb, hw, vw;
    bit e_pclk, e_hs, e_vs, e_den;
    p = 2 * (k_div + 1);
    ht = k_hs + k_hb + k_ha + k_hf + 4;
    vt = k_vs + k_vb + k_va + k_vf + 4;
    hw = 0; vw = 0;
    if (m_run == 0) begin
      latch_cfg(); m_div = 0; m_h = 0; m_v = 0;
    end else begin
      stb = (m_div == p - 1);
      m_div = stb ? 0 : m_div + 1;
      if (stb) begin
        hw = (m_h == ht - 1);
        m_h = hw ? 0 : m_h + 1;
        if (hw) begin
          vw = (m_v == vt - 1);
          m_v = vw ? 0 : m_v + 1;
          if (vw) latch_cfg();
        end
      end
    end
    m_fs = ctrl[0] && (m_run == 0 || vw);
    m_ls = ctrl[0] && (m_run == 0 || hw);
    m_run = ctrl[0];
    @(negedge clk_i);
    p = 2 * (k_div + 1);
    hb0 = k_hs + k_hb + 2;
    vb0 = k_vs + k_vb + 2;
    dena = (m_run != 0) && m_h >= hb0 && m_h <= hb0 + k_ha && m_v >= vb0 && m_v <= vb0 + k_va;
    e_pclk = (m_run != 0) && ((m_div <= k_div) ^ k_ctrl[4]);
    e_hs = ((m_run != 0) && m_h <= k_hs) ^ k_ctrl[1];
    e_vs = ((m_run != 0) && m_v <= k_vs) ^ k_ctrl[2];
    e_den = (dena != 0) ^ k_ctrl[3];
    if (pix_stb_o !== ((m_run != 0) && m_div == p - 1)) err[0]++;
    if (pix_clk_o !== e_pclk) err[1]++;
    if (hsync_o !== e_hs) err[2]++;
    if (vsync_o !== e_vs) err[3]++;
    if (den_o !== e_den || int'(x_o) != (dena ? m_h - hb0 : 0) ||
        int'(y_o) != (dena ? m_v - vb0 : 0)) err[4]++;
    if (frame_start_o !== m_fs[0] || line_start_o !== m_ls[0]) err[5]++;
  endtask

  function automatic int err_sum();
    return err[0] + err[1] + err[2] + err[3] + err[4] + err[5];
  endfunction

  task automatic run_scen(input string tag, input int n);
    foreach (err[i]) err[i] = 0;
    repeat (n) tick();
    check({tag, " R1 pixel strobe period"}, err[0], 0);
    check({tag, " R2 pixel clock phase"}, err[1], 0);
    check({tag, " R3 hsync and line length"}, err[2], 0);
    check({tag, " R4 vsync and frame length"}, err[3], 0);
    check({tag, " R5 den and coordinates"}, err[4], 0);
    check({tag, " R9 line/frame pulses"}, err[5], 0);
  endtask

  task automatic rand_cfg(input bit run);
    dv = 8'($urandom_range(2, 0));
    hs = 10'($urandom_range(3, 0)); hb = 10'($urandom_range(3, 0));
    ha = 10'($urandom_range(5, 0)); hf = 10'($urandom_range(3, 0));
    vs = 10'($urandom_range(2, 0)); vb = 10'($urandom_range(2, 0));
    va = 10'($urandom_range(4, 0)); vf = 10'($urandom_range(2, 0));
    ctrl = {4'($urandom_range(15, 0)), run};
  endtask

  task automatic stop_for(input int n);
    ctrl[0] = 1'b0;
    repeat (n) tick();
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_ni = 1'b0;
    ctrl = '0; dv = '0;
    hs = '0; hb = '0; ha = '0; hf = '0; vs = '0; vb = '0; va = '0; vf = '0;
    m_run = 0; m_div = 0; m_h = 0; m_v = 0; m_fs = 0; m_ls = 0;
    k_ctrl = 0; k_div = 0; k_hs = 0; k_hb = 0; k_ha = 0; k_hf = 0;
    k_vs = 0; k_vb = 0; k_va = 0; k_vf = 0;
    ctrl[1] = 1'b1;  // polarity input must not reach outputs during reset
    repeat (3) @(negedge clk_i);
    check("R7 reset state", int'({pix_stb_o, pix_clk_o, hsync_o, vsync_o, den_o,
          line_start_o, frame_start_o}) + int'(x_o) + int'(y_o), 0);
    ctrl = '0;
    rst_ni = 1'b1;
    stop_for(2);

    // minimum geometry, all fields zero
    ctrl = 5'b00001;
    run_scen("min", 3 * frame_len() + 3);
    stop_for(3);

    // wide divider, hand-picked porches
    dv = 8'd3; hs = 10'd2; hb = 10'd1; ha = 10'd4; hf = 10'd0;
    vs = 10'd1; vb = 10'd0; va = 10'd2; vf = 10'd1;
    ctrl = 5'b00001;
    run_scen("directed", 2 * frame_len() + 5);
    stop_for(3);

    // all inversions and rising-edge capture
    ctrl = 5'b11111;
    run_scen("inverted", 2 * frame_len() + 5);
    check("R6 polarity inversion", err[2] + err[3] + err[4], 0);
    stop_for(4);
    check("R6 idle levels follow inversion", int'({hsync_o, vsync_o, den_o}), 7);

    for (int i = 0; i < 8; i++) begin
      rand_cfg(1'b1);
      run_scen("random", 2 * frame_len() + 7);
      stop_for(3);
    end

    // mid-frame change must wait for frame wrap
    rand_cfg(1'b1);
    run_scen("pre-change", frame_len() / 2 + 1);
    rand_cfg(1'b1);
    dv = 8'd1;
    foreach (err[i]) err[i] = 0;
    repeat (3 * 2 * 2 * 18 * 13) tick();
    check("R8 config applied only at frame start", err_sum(), 0);

    // stop mid-frame, then restart
    foreach (err[i]) err[i] = 0;
    stop_for(40);
    check("R7 stopped outputs inactive", err_sum(), 0);
    check("R7 stopped strobe and pulses", int'({pix_stb_o, line_start_o, frame_start_o}), 0);
    ctrl[0] = 1'b1;
    tick();
    check("R9 frame_start on restart", int'(frame_start_o), 1);
    run_scen("restart", 2 * frame_len());

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R9 actual=timeout expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule